// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through Output

This block is a first-in first-out buffer of 18-bit words whose write side and read side run on two unrelated clocks. Write and read positions are held as binary counters in their own domains. Each is handed to the other domain as a Gray-coded register that passes through a two-flop synchroniser. Fullness and its companion levels are worked out on the write clock, and emptiness and the almost-empty level on the read clock.

A static mode pin picks how the read side behaves. In request mode a word is fetched from storage only when the reader asks, and it appears on the data output after that read clock edge. In fall-through mode the block moves the oldest word into an output stage on its own. That stage counts as one extra slot, so the buffer holds one word more than the RAM. The status pins change polarity and reset value with the mode. There is also an almost-empty flag, an almost-full flag and a half-full flag, plus two resets. A master reset restores the default offsets. A partial reset empties the buffer but keeps any offsets that were loaded.

Top module: `dual_clk_fifo`

## Requirements
- R1: While `mrst` or `prst` is high, and after it falls until the next accepted write, the flags read as follows. `rd_flag` is 0 in request mode (`fwft_mode`=0) and 1 in fall-through mode (`fwft_mode`=1). `wr_flag` is 1 in request mode and 0 in fall-through mode. `pae_n` is 0, and `paf_n` and `hf_n` are 1.
- R2: In request mode, `rd_flag` goes to 1 (data present) within six read clock cycles of the first write. `dout` keeps its previous word until a read clock edge with `ren`=1 while `rd_flag`=1. After that edge it shows the oldest stored word.
- R3: In fall-through mode, within eight read clock cycles of a write into an empty buffer, `rd_flag` goes to 0 (output valid) and `dout` shows that word with `ren` held at 0. A read edge with `ren`=1 while `rd_flag`=0 consumes the shown word.
- R4: Words leave in the order they were accepted, in both modes.
- R5: Let D = 2^AW. In request mode `wr_flag` falls to 0 (full) after D stored words. In fall-through mode `wr_flag` stays 0 with D stored words and rises to 1 (full) only at D+1.
- R6: A write while full is dropped. No stored word changes and the write position does not move.
- R7: A read request while nothing is stored is ignored. The read position does not move and `rd_flag` stays at its empty value.
- R8: Take the RAM occupancy as seen on the write clock. `paf_n` is 0 when that occupancy is at least D minus the full offset m.
- R9: Take the words held as seen on the read clock: the RAM words plus, in fall-through mode, the output-stage word. `pae_n` is 0 while that count is at most the empty offset n.
- R10: `hf_n` is 0 when the write-side RAM occupancy exceeds D/2.
- R11: `af_ld` (write clock) loads m from `af_val`, and `ae_ld` (read clock) loads n from `ae_val`. `prst` keeps both values. `mrst` restores `AF_DEFAULT` and `AE_DEFAULT`.
- R12: With `oe`=0, `dout` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, synchronous active-high, seen by both clocks |
| prst | input | 1 | Partial reset; empties the buffer and keeps the offsets |
| fwft_mode | input | 1 | 0 selects request mode, 1 selects fall-through mode; change only under `mrst` |
| wen | input | 1 | Write request |
| din | input | DW | Write data |
| af_ld | input | 1 | Load the almost-full offset (write clock) |
| af_val | input | AW | Almost-full offset value |
| ren | input | 1 | Read request |
| oe | input | 1 | Output enable; 0 forces `dout` to zero |
| ae_ld | input | 1 | Load the almost-empty offset (read clock) |
| ae_val | input | AW | Almost-empty offset value |
| dout | output | DW | Read data |
| rd_flag | output | 1 | Empty flag (active low) in request mode; output-not-ready (active high) in fall-through mode |
| wr_flag | output | 1 | Full flag (active low) in request mode; input-not-ready (active high) in fall-through mode |
| pae_n | output | 1 | Almost empty, active low |
| paf_n | output | 1 | Almost full, active low |
| hf_n | output | 1 | Half full, active low |

## Verification
The bench builds the block with AW=3, giving eight RAM slots, and default offsets of 2. Every fill level can then be visited one word at a time. The half-full step between four and five words and the almost-full step at six can each be checked. The request-mode full point at eight and the fall-through full point at nine can both be reached. A reprogrammed full offset of 1 moves the almost-full step to seven, which shows that the offset survives a partial reset and returns to its default after a master reset.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
  typedef enum logic {
    MODE_REQ  = 1'b0,
    MODE_FALL = 1'b1
  } dcf_mode_e;

  typedef struct packed {
    logic full;
    logic almost_full;
    logic half_full;
  } dcf_wflags_t;
endpackage

// File: rtl/dcf_ram.sv
`timescale 1ns/1ps
module dcf_ram #(
  parameter int AW = 4,
  parameter int DW = 18
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read port, no reset, so it maps onto block RAM
  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dcf_ptr_sync.sv
`timescale 1ns/1ps
module dcf_ptr_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= gray_in;
      stage2 <= stage1;
    end
  end

  always_comb begin
    for (int i = 0; i < W; i++) begin
      bin_out[i] = ^(stage2 >> i);
    end
  end
endmodule

// File: rtl/dcf_wr_side.sv
`timescale 1ns/1ps
module dcf_wr_side
  import dcf_pkg::*;
#(
  parameter int AW         = 4,
  parameter int AF_DEFAULT = 4
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          wen,
  input  logic          af_ld,
  input  logic [AW-1:0] af_val,
  input  logic [AW:0]   rq_bin,
  output logic [AW:0]   wbin,
  output logic [AW:0]   wgray,
  output logic          accept,
  output dcf_wflags_t   flags
);
  localparam int            DEPTH   = 1 << AW;
  localparam logic [AW:0]   DEPTH_V = DEPTH[AW:0];
  localparam logic [AW:0]   HALF_V  = DEPTH_V >> 1;
  localparam logic [AW-1:0] AF_RST  = AW'(AF_DEFAULT);

  logic [AW-1:0] af_off;
  logic [AW:0]   wbin_nxt;
  logic [AW:0]   level_nxt;
  logic [AW:0]   af_thr;

  assign accept    = wen & ~flags.full;
  assign wbin_nxt  = wbin + {{AW{1'b0}}, accept};
  assign level_nxt = wbin_nxt - rq_bin;
  assign af_thr    = DEPTH_V - {1'b0, af_off};

  always_ff @(posedge clk) begin
    if (mrst | prst) begin
      wbin  <= '0;
      wgray <= '0;
      flags <= '0;
    end else begin
      wbin              <= wbin_nxt;
      wgray             <= wbin_nxt ^ (wbin_nxt >> 1);
      flags.full        <= (level_nxt == DEPTH_V);
      flags.almost_full <= (level_nxt >= af_thr);
      flags.half_full   <= (level_nxt > HALF_V);
    end
  end

  // offset survives the partial reset
  always_ff @(posedge clk) begin
    if (mrst)       af_off <= AF_RST;
    else if (af_ld) af_off <= af_val;
  end
endmodule

// File: rtl/dcf_rd_side.sv
`timescale 1ns/1ps
module dcf_rd_side #(
  parameter int AW         = 4,
  parameter int AE_DEFAULT = 4
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          fall,
  input  logic          ren,
  input  logic          ae_ld,
  input  logic [AW-1:0] ae_val,
  input  logic [AW:0]   wq_bin,
  output logic [AW:0]   rbin,
  output logic [AW:0]   rgray,
  output logic          fetch,
  output logic          empty,
  output logic          valid,
  output logic          almost_empty
);
  localparam logic [AW-1:0] AE_RST = AW'(AE_DEFAULT);

  logic [AW-1:0] ae_off;
  logic [AW:0]   rbin_nxt;
  logic [AW:0]   ram_lvl_nxt;
  logic [AW:0]   held_nxt;
  logic          valid_nxt;

  // request mode: fetch on demand; fall-through: refill the output stage
  assign fetch       = ~empty & (fall ? (~valid | ren) : ren);
  assign rbin_nxt    = rbin + {{AW{1'b0}}, fetch};
  assign ram_lvl_nxt = wq_bin - rbin_nxt;
  assign valid_nxt   = fall & (fetch | (valid & ~ren));
  assign held_nxt    = ram_lvl_nxt + {{AW{1'b0}}, valid_nxt};

  always_ff @(posedge clk) begin
    if (mrst | prst) begin
      rbin         <= '0;
      rgray        <= '0;
      empty        <= 1'b1;
      valid        <= 1'b0;
      almost_empty <= 1'b1;
    end else begin
      rbin         <= rbin_nxt;
      rgray        <= rbin_nxt ^ (rbin_nxt >> 1);
      empty        <= (ram_lvl_nxt == '0);
      valid        <= valid_nxt;
      almost_empty <= (held_nxt <= {1'b0, ae_off});
    end
  end

  always_ff @(posedge clk) begin
    if (mrst)       ae_off <= AE_RST;
    else if (ae_ld) ae_off <= ae_val;
  end
endmodule

// File: rtl/dual_clk_fifo.sv
`timescale 1ns/1ps
module dual_clk_fifo
  import dcf_pkg::*;
#(
  parameter int AW         = 4,
  parameter int DW         = 18,
  parameter int AE_DEFAULT = 4,
  parameter int AF_DEFAULT = 4
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          fwft_mode,
  input  logic          wen,
  input  logic [DW-1:0] din,
  input  logic          af_ld,
  input  logic [AW-1:0] af_val,
  input  logic          ren,
  input  logic          oe,
  input  logic          ae_ld,
  input  logic [AW-1:0] ae_val,
  output logic [DW-1:0] dout,
  output logic          rd_flag,
  output logic          wr_flag,
  output logic          pae_n,
  output logic          paf_n,
  output logic          hf_n
);
  dcf_mode_e   mode;
  logic        fall;
  logic [AW:0] wbin, wgray, rbin, rgray;
  logic [AW:0] rq_bin, wq_bin;
  logic        accept, fetch;
  logic        rempty, rvalid, raempty;
  dcf_wflags_t wfl;
  logic [DW-1:0] ram_q;

  assign mode = dcf_mode_e'(fwft_mode);
  assign fall = (mode == MODE_FALL);

  dcf_wr_side #(.AW(AW), .AF_DEFAULT(AF_DEFAULT)) wr_i (
    .clk(wclk), .mrst(mrst), .prst(prst), .wen(wen),
    .af_ld(af_ld), .af_val(af_val), .rq_bin(rq_bin),
    .wbin(wbin), .wgray(wgray), .accept(accept), .flags(wfl)
  );

  dcf_rd_side #(.AW(AW), .AE_DEFAULT(AE_DEFAULT)) rd_i (
    .clk(rclk), .mrst(mrst), .prst(prst), .fall(fall), .ren(ren),
    .ae_ld(ae_ld), .ae_val(ae_val), .wq_bin(wq_bin),
    .rbin(rbin), .rgray(rgray), .fetch(fetch), .empty(rempty),
    .valid(rvalid), .almost_empty(raempty)
  );

  dcf_ptr_sync #(.W(AW+1)) w2r_i (
    .clk(rclk), .rst(mrst | prst), .gray_in(wgray), .bin_out(wq_bin)
  );

  dcf_ptr_sync #(.W(AW+1)) r2w_i (
    .clk(wclk), .rst(mrst | prst), .gray_in(rgray), .bin_out(rq_bin)
  );

  dcf_ram #(.AW(AW), .DW(DW)) ram_i (
    .wclk(wclk), .we(accept), .waddr(wbin[AW-1:0]), .wdata(din),
    .rclk(rclk), .re(fetch), .raddr(rbin[AW-1:0]), .rdata(ram_q)
  );

  assign dout    = oe ? ram_q : '0;
  assign rd_flag = fall ? ~rvalid : ~rempty;
  assign wr_flag = fall ? wfl.full : ~wfl.full;
  assign pae_n   = ~raempty;
  assign paf_n   = ~wfl.almost_full;
  assign hf_n    = ~wfl.half_full;
endmodule

// File: rtl/dcf_chk.sv
`timescale 1ns/1ps
module dcf_chk #(
  parameter int AW = 4,
  parameter int DW = 18
) (
  input logic          wclk,
  input logic          rclk,
  input logic          mrst,
  input logic          prst,
  input logic          fwft_mode,
  input logic          wen,
  input logic          ren,
  input logic          wfull,
  input logic [AW:0]   wbin,
  input logic          rempty,
  input logic [AW:0]   rbin,
  input logic          rvalid,
  input logic [DW-1:0] ram_q,
  input logic          paf_n,
  input logic          hf_n
);
  // R6
  no_overflow_chk: assert property (@(posedge wclk) disable iff (mrst || prst)
    (wfull && wen) |=> $stable(wbin));

  // R7
  no_underflow_chk: assert property (@(posedge rclk) disable iff (mrst || prst)
    (rempty && ren) |=> $stable(rbin));

  // R8 R10
  full_levels_chk: assert property (@(posedge wclk) disable iff (mrst || prst)
    wfull |=> (!paf_n && !hf_n) || !wfull);

  // R3
  head_hold_chk: assert property (@(posedge rclk) disable iff (mrst || prst)
    (fwft_mode && rvalid && !ren) |=> (rvalid && $stable(ram_q)));

  // R2
  req_only_chk: assert property (@(posedge rclk) disable iff (mrst || prst)
    (!fwft_mode && !ren) |=> $stable(ram_q));
endmodule

bind dual_clk_fifo dcf_chk #(.AW(AW), .DW(DW)) chk_i (
  .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst), .fwft_mode(fwft_mode),
  .wen(wen), .ren(ren), .wfull(wfl.full), .wbin(wbin), .rempty(rempty),
  .rbin(rbin), .rvalid(rvalid), .ram_q(ram_q), .paf_n(paf_n), .hf_n(hf_n)
);

// File: tb/dual_clk_fifo_tb_top.sv
`timescale 1ns/1ps
module dual_clk_fifo_tb_top;
  localparam int WCLK_PERIOD = 10;
  localparam int RCLK_PERIOD = 16;
  localparam int AW = 3;
  localparam int DW = 18;
  localparam int D  = 1 << AW;

  logic wclk = 0, rclk = 0;
  logic mrst = 1, prst = 0, fwft_mode = 0;
  logic wen = 0, ren = 0, oe = 0, af_ld = 0, ae_ld = 0;
  logic [DW-1:0] din = '0;
  logic [AW-1:0] af_val = '0, ae_val = '0;
  logic [DW-1:0] dout;
  logic rd_flag, wr_flag, pae_n, paf_n, hf_n;

  int checks = 0, errors = 0;
  bit done = 0;
  bit pend = 0;
  logic [DW-1:0] exp_q[$];

  always #(WCLK_PERIOD/2) wclk = ~wclk;
  always #(RCLK_PERIOD/2) rclk = ~rclk;

  dual_clk_fifo #(.AW(AW), .DW(DW), .AE_DEFAULT(2), .AF_DEFAULT(2)) dut_i (
    .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst), .fwft_mode(fwft_mode),
    .wen(wen), .din(din), .af_ld(af_ld), .af_val(af_val),
    .ren(ren), .oe(oe), .ae_ld(ae_ld), .ae_val(ae_val),
    .dout(dout), .rd_flag(rd_flag), .wr_flag(wr_flag),
    .pae_n(pae_n), .paf_n(paf_n), .hf_n(hf_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as words leave the design
  always @(negedge rclk) begin
    if (pend) begin
      pend = 0;
      if (exp_q.size() == 0) chk("R4 unexpected word", 32'(dout), 32'hDEAD);
      else chk("R4 order", 32'(dout), 32'(exp_q.pop_front()));
    end
    if (!fwft_mode && ren && rd_flag) pend = 1;
    if (fwft_mode && ren && !rd_flag) begin
      if (exp_q.size() == 0) chk("R4 unexpected word", 32'(dout), 32'hDEAD);
      else chk("R4 order", 32'(dout), 32'(exp_q.pop_front()));
    end
  end

  task automatic wstep(input int n);
    repeat (n) @(posedge wclk);
    #2;
  endtask

  task automatic rsettle(input int n);
    repeat (n) @(negedge rclk);
  endtask

  task automatic do_reset(input bit master, input bit mode);
    wstep(1);
    wen = 0;
    if (master) begin mrst = 1; fwft_mode = mode; end
    else prst = 1;
    #120;
    wstep(1);
    mrst = 0; prst = 0;
    exp_q.delete();
    pend = 0;
    rsettle(1);
  endtask

  task automatic check_reset_flags(input string tag);
    chk({tag, " rd_flag"}, 32'(rd_flag), 32'(fwft_mode));
    chk({tag, " wr_flag"}, 32'(wr_flag), 32'(!fwft_mode));
    chk({tag, " pae_n"}, 32'(pae_n), 0);
    chk({tag, " paf_n"}, 32'(paf_n), 1);
    chk({tag, " hf_n"}, 32'(hf_n), 1);
  endtask

  task automatic push(input logic [DW-1:0] d);
    wstep(1);
    while (fwft_mode ? wr_flag : !wr_flag) wstep(1);
    wen = 1; din = d; exp_q.push_back(d);
    wstep(1);
    wen = 0;
  endtask

  task automatic read_for(input int n);
    @(posedge rclk); #2;
    ren = 1;
    repeat (n) @(posedge rclk);
    #2;
    ren = 0;
  endtask

  task automatic wait_rd(input logic val, input int maxc, output int lat);
    lat = 0;
    while (rd_flag !== val && lat < maxc) begin
      @(negedge rclk);
      lat++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int lat;
    logic [DW-1:0] xw;
    // ---------- request mode ----------
    do_reset(1, 0);
    check_reset_flags("R1 req mrst");
    chk("R12 oe low", 32'(dout), 0);
    oe = 1;

    read_for(3);                       // R7 read while empty
    rsettle(2);
    chk("R7 rd_flag after empty read", 32'(rd_flag), 0);

    xw = 18'h2A5A5;
    push(xw);
    wait_rd(1, 10, lat);
    chk("R2 flag latency", 32'(lat <= 6), 1);
    read_for(1);
    rsettle(3);
    chk("R7 pointer unmoved", 32'(exp_q.size()), 0);

    push(18'h11111);                   // R2 held until requested
    wait_rd(1, 10, lat);
    rsettle(4);
    chk("R2 dout held", 32'(dout), 32'(xw));
    read_for(1);
    rsettle(3);
    chk("R2 read done", 32'(exp_q.size()), 0);

    for (int k = 1; k <= D; k++) begin
      push(DW'(18'h100 + k));
      rsettle(8);
      chk("R9 pae_n", 32'(pae_n), 32'(k > 2));
      chk("R10 hf_n", 32'(hf_n), 32'(k <= D/2));
      chk("R8 paf_n", 32'(paf_n), 32'(k < D - 2));
      chk("R5 wr_flag", 32'(wr_flag), 32'(k != D));
    end
    wstep(1);
    wen = 1; din = 18'h3FFFF;          // R6 dropped write
    wstep(1);
    wen = 0;
    rsettle(2);
    chk("R6 still full", 32'(wr_flag), 0);
    read_for(30);
    rsettle(8);
    chk("R6 nothing extra stored", 32'(rd_flag), 0);
    chk("R4 drained", 32'(exp_q.size()), 0);

    // ---------- offsets across resets ----------
    wstep(1); af_ld = 1; af_val = 3'd1; wstep(1); af_ld = 0;
    @(posedge rclk); #2; ae_ld = 1; ae_val = 3'd0; @(posedge rclk); #2; ae_ld = 0;
    push(18'h5); push(18'h6); push(18'h7);
    do_reset(0, 0);
    check_reset_flags("R1 req prst");
    for (int k = 1; k <= 7; k++) begin
      push(DW'(18'h200 + k));
      rsettle(8);
      if (k == 1) chk("R11 kept n", 32'(pae_n), 1);
      if (k == 6) chk("R11 kept m below", 32'(paf_n), 1);
      if (k == 7) chk("R11 kept m at", 32'(paf_n), 0);
    end
    read_for(30);
    rsettle(8);
    chk("R4 drained after prst", 32'(exp_q.size()), 0);

    do_reset(1, 0);
    for (int k = 1; k <= 6; k++) begin
      push(DW'(18'h300 + k));
      rsettle(8);
      if (k == 2) chk("R11 default n", 32'(pae_n), 0);
      if (k == 6) chk("R11 default m", 32'(paf_n), 0);
    end
    read_for(30);
    rsettle(8);

    // ---------- fall-through mode ----------
    do_reset(1, 1);
    check_reset_flags("R1 fall mrst");
    xw = 18'h0BEEF;
    push(xw);
    wait_rd(0, 12, lat);
    chk("R3 valid latency", 32'(lat <= 8), 1);
    chk("R3 head shown", 32'(dout), 32'(xw));
    wstep(6);
    for (int k = 2; k <= D + 1; k++) begin
      push(DW'(18'h400 + k));
      rsettle(8);
      if (k == 2) chk("R9 fall pae_n 2 held", 32'(pae_n), 0);
      if (k == 3) chk("R9 fall pae_n 3 held", 32'(pae_n), 1);
      if (k == D) chk("R5 fall not full at D", 32'(wr_flag), 0);
      if (k == D + 1) chk("R5 fall full at D+1", 32'(wr_flag), 1);
    end
    oe = 0;
    rsettle(1);
    chk("R12 oe low fall", 32'(dout), 0);
    oe = 1;
    rsettle(1);
    chk("R3 head still shown", 32'(dout), 32'(xw));
    read_for(40);
    rsettle(8);
    chk("R4 fall drained", 32'(exp_q.size()), 0);
    chk("R3 no valid after drain", 32'(rd_flag), 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule